// File: doc/BRIEF.md
# SOF/EOP Timeout Watchdog Monitor

This block checks that frame markers keep arriving on a USB peripheral port. A full-speed host sends a start-of-frame (SOF) packet every millisecond, and a low-speed host sends an end-of-packet (EOP) keep-alive at the same rate. The block runs a 14-bit down counter on a 12 MHz tick enable. Every marker restarts the counter from a programmable reload value. If the counter runs out before the next marker arrives, the block records a timeout event.

The monitor publishes three things:
- a read-only current count;
- a packed status word holding a sticky timeout flag, a saturating 3-bit tally of missed markers, and the frame number of the last full-speed SOF;
- an interrupt request, which is the flag gated by the timeout interrupt enable.

Software writes the reload value slightly above the expected interval. It clears the flag with a single-cycle clear strobe.

The flag logic is a two-state machine:
- `FLG_QUIET`: the flag is clear. The transition *raise* (a timeout event) moves to `FLG_ALERT`.
- `FLG_ALERT`: the flag is set. The transition *acknowledge* (the clear strobe with no timeout in the same cycle) moves back to `FLG_QUIET`.
- Every other case holds the state.

Top module: `sofwd_monitor`

## Requirements
- R1: In a cycle with `tick` high, no marker strobe, and a non-zero count, the current count decrements by exactly one. With `tick` low and no marker strobe, the count holds.
- R2: After reset, the reload value and the current count are both 0x2EE0 (12000), the status word is 0 and `irq` is 0.
- R3: A cycle with `tick` high, no marker strobe and the count at 0 is a timeout event. On the next edge the count takes the reload value, and it keeps counting on later ticks.
- R4: A cycle with `sof_stb` or `eop_stb` high loads the count from the reload register on the next edge, whatever `tick` is. The reload register value used is the one held before any write in that same cycle.
- R5: A reload write takes `reload_wdata[13:0]` and ignores bits 15:14. `count_rd[13:0]` is the current count and `count_rd[15:14]` reads 0.
- R6: `status_rd` carries the flag at bit 15, the tally at bits 14:12, 0 at bit 11, and the frame number at bits 10:0.
- R7: Every timeout event sets the flag, whether or not the enable is set. The flag stays set until a cycle with `flag_clr` high. If a timeout happens in the same cycle as the clear, the flag stays set.
- R8: While `tmo_ie` is high, each timeout adds one to the tally, up to 7, where it stays. A marker strobe clears the tally to 0. While `tmo_ie` is low the tally does not change.
- R9: An `sof_stb` with `low_speed` low loads `sof_frame` into the frame field. An SOF with `low_speed` high, an EOP and a timeout all leave the frame field unchanged.
- R10: `irq` is high exactly when the flag is set and `tmo_ie` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | 12 MHz count enable |
| sof_stb | input | 1 | SOF received, one cycle |
| sof_frame | input | 11 | Frame number carried by the SOF |
| eop_stb | input | 1 | EOP keep-alive received, one cycle |
| low_speed | input | 1 | 1 = low-speed port, 0 = full-speed port |
| tmo_ie | input | 1 | Timeout interrupt enable |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_wdata | input | 16 | Reload write data; bits 15:14 are ignored |
| flag_clr | input | 1 | Clear strobe for the timeout flag (write one to clear) |
| count_rd | output | 16 | Current count, zero-extended |
| status_rd | output | 16 | Packed flag, tally, reserved bit and frame number |
| irq | output | 1 | Timeout interrupt request |

## Verification
Each signal can go wrong in its own way:
- A counter that decrements wrongly or reloads from the wrong source shows up at `count_rd` on the very next clock. It then shifts every later timeout, so the error also appears as an early or late flag.
- A flag state machine that drops or misses a transition shows at `status_rd[15]` and `irq` in the cycle after the clear or timeout.
- A tally that wraps or ignores the enable only becomes visible once eight or more timeouts have happened without a marker. The bench therefore runs long strings of missed markers with the enable both on and off.
- A frame field that loads in low-speed mode differs from the reference after the first low-speed SOF that carries a new number.

// File: rtl/sofwd_pkg.sv
package sofwd_pkg;
    // Width of the software-visible count and status words
    localparam int REG_W = 16;

    // Sticky timeout flag states
    typedef enum logic [0:0] {
        FLG_QUIET = 1'b0,
        FLG_ALERT = 1'b1
    } flag_state_t;
endpackage

// File: rtl/sofwd_counter.sv
module sofwd_counter #(
    parameter int CNT_W       = 14,
    parameter int RESET_COUNT = 12000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             mark,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_in,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] INIT_VAL = CNT_W'(RESET_COUNT);

    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count_q;

    // Timeout event: a tick arrives while the count is already at zero
    assign expire = tick && !mark && (count_q == '0);
    assign count  = count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= INIT_VAL;
        end else if (reload_we) begin
            reload_q <= reload_in;
        end
    end

    // Priority: marker reload, then expiry reload, then decrement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= INIT_VAL;
        end else if (mark) begin
            count_q <= reload_q;
        end else if (tick) begin
            if (count_q == '0) begin
                count_q <= reload_q;
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !mark && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !mark) |=> $stable(count_q));

    a_r4_mark_reload: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> (count_q == $past(reload_q)));

    a_r3_expire_reload: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/sofwd_status.sv
module sofwd_status
    import sofwd_pkg::*;
#(
    parameter int FRAME_W = 11,
    parameter int TALLY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire,
    input  logic               mark,
    input  logic               sof_fs,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               ie,
    input  logic               clr,
    output logic               flag,
    output logic [TALLY_W-1:0] tally,
    output logic [FRAME_W-1:0] frame
);
    localparam logic [TALLY_W-1:0] TALLY_MAX = {TALLY_W{1'b1}};

    flag_state_t state_q, state_d;
    logic [TALLY_W-1:0] tally_q;
    logic [FRAME_W-1:0] frame_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLG_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: raise (QUIET->ALERT), acknowledge (ALERT->QUIET)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_QUIET: if (expire)         state_d = FLG_ALERT;
            FLG_ALERT: if (clr && !expire) state_d = FLG_QUIET;
            default:                       state_d = FLG_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        flag  = (state_q == FLG_ALERT);
        tally = tally_q;
        frame = frame_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tally_q <= '0;
        end else if (ie) begin
            if (mark) begin
                tally_q <= '0;
            end else if (expire && tally_q != TALLY_MAX) begin
                tally_q <= tally_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (sof_fs) begin
            frame_q <= frame_in;
        end
    end

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    a_r7_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (tally_q == TALLY_MAX && !mark) |=> (tally_q == TALLY_MAX));

    a_r8_ie_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |=> $stable(tally_q));

    a_r9_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_fs |=> $stable(frame_q));
endmodule

// File: rtl/sofwd_monitor.sv
module sofwd_monitor
    import sofwd_pkg::*;
#(
    parameter int CNT_W       = 14,
    parameter int FRAME_W     = 11,
    parameter int TALLY_W     = 3,
    parameter int RESET_COUNT = 12000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               sof_stb,
    input  logic [FRAME_W-1:0] sof_frame,
    input  logic               eop_stb,
    input  logic               low_speed,
    input  logic               tmo_ie,
    input  logic               reload_we,
    input  logic [REG_W-1:0]   reload_wdata,
    input  logic               flag_clr,
    output logic [REG_W-1:0]   count_rd,
    output logic [REG_W-1:0]   status_rd,
    output logic               irq
);
    localparam int CNT_PAD = REG_W - CNT_W;
    localparam int ST_PAD  = REG_W - 1 - TALLY_W - FRAME_W;

    logic               mark;
    logic               sof_fs;
    logic               expire;
    logic [CNT_W-1:0]   count;
    logic               flag;
    logic [TALLY_W-1:0] tally;
    logic [FRAME_W-1:0] frame;
    logic               unused_hi;

    assign mark      = sof_stb || eop_stb;
    assign sof_fs    = sof_stb && !low_speed;
    assign unused_hi = ^reload_wdata[REG_W-1:CNT_W];

    sofwd_counter #(
        .CNT_W       (CNT_W),
        .RESET_COUNT (RESET_COUNT)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mark      (mark),
        .reload_we (reload_we),
        .reload_in (reload_wdata[CNT_W-1:0]),
        .count     (count),
        .expire    (expire)
    );

    sofwd_status #(
        .FRAME_W (FRAME_W),
        .TALLY_W (TALLY_W)
    ) i_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (expire),
        .mark     (mark),
        .sof_fs   (sof_fs),
        .frame_in (sof_frame),
        .ie       (tmo_ie),
        .clr      (flag_clr),
        .flag     (flag),
        .tally    (tally),
        .frame    (frame)
    );

    assign count_rd  = {{CNT_PAD{1'b0}}, count};
    assign status_rd = {flag, tally, {ST_PAD{1'b0}}, frame};
    assign irq       = flag && tmo_ie;

    a_r10_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !tmo_ie |-> !irq);

    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd[FRAME_W] == 1'b0);
endmodule

// File: tb/test_sofwd_monitor.sv
module test_sofwd_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        sof_stb = 1'b0;
    logic [10:0] sof_frame = '0;
    logic        eop_stb = 1'b0;
    logic        low_speed = 1'b0;
    logic        tmo_ie = 1'b0;
    logic        reload_we = 1'b0;
    logic [15:0] reload_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] count_rd;
    logic [15:0] status_rd;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    int tick_mode = 0;   // 0 none, 1 every cycle, 2 every third cycle
    int tick_ph = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int m_reload = 12000;
    int m_count  = 12000;
    int m_flag   = 0;
    int m_tally  = 0;
    int m_frame  = 0;

    always #4 clk = ~clk;   // 125 MHz

    sofwd_monitor i_sofwd_monitor (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sof_stb(sof_stb),
        .sof_frame(sof_frame), .eop_stb(eop_stb), .low_speed(low_speed),
        .tmo_ie(tmo_ie), .reload_we(reload_we), .reload_wdata(reload_wdata),
        .flag_clr(flag_clr), .count_rd(count_rd), .status_rd(status_rd), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model, updated on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_reload = 12000; m_count = 12000; m_flag = 0; m_tally = 0; m_frame = 0;
        end else begin
            int to;
            int mk;
            to = 0;
            mk = (sof_stb || eop_stb) ? 1 : 0;
            if (mk) m_count = m_reload;
            else if (tick) begin
                if (m_count == 0) begin to = 1; m_count = m_reload; end
                else m_count = m_count - 1;
            end
            if (to) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (tmo_ie) begin
                if (mk) m_tally = 0;
                else if (to && m_tally < 7) m_tally = m_tally + 1;
            end
            if (sof_stb && !low_speed) m_frame = sof_frame;
            if (reload_we) m_reload = reload_wdata & 16'h3FFF;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1/R3/R4 count",   count_rd[13:0], m_count);
            check("R5 count hi",      count_rd[15:14], 0);
            check("R7 flag",          status_rd[15], m_flag);
            check("R8 tally",         status_rd[14:12], m_tally);
            check("R6 reserved bit",  status_rd[11], 0);
            check("R9 frame",         status_rd[10:0], m_frame);
            check("R10 irq",          irq, (m_flag != 0 && tmo_ie) ? 1 : 0);
        end
    end

    // Tick generator
    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % 3;
        case (tick_mode)
            1: tick <= 1'b1;
            2: tick <= (tick_ph == 0);
            default: tick <= 1'b0;
        endcase
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sof(input int fr);
        sof_frame <= 11'(fr); sof_stb <= 1'b1;
        @(negedge clk); sof_stb <= 1'b0;
    endtask

    task automatic eop();
        eop_stb <= 1'b1;
        @(negedge clk); eop_stb <= 1'b0;
    endtask

    initial begin
        cyc(3);
        // R2: reset values, before reset release
        check("R2 count at reset",  count_rd, 16'h2EE0);
        check("R2 status at reset", status_rd, 0);
        check("R2 irq at reset",    irq, 0);
        rst_n <= 1'b1;
        cyc(2);
        // R1: hold without tick
        check("R1 hold no tick", count_rd, 16'h2EE0);
        // R3: default interval runs out with tick every cycle, ie low
        tick_mode = 1;
        cyc(12010);
        check("R7 flag after default timeout", status_rd[15], 1);
        check("R8 tally frozen ie low", status_rd[14:12], 0);
        check("R10 irq masked", irq, 0);
        // R5: reserved reload bits ignored
        reload_wdata <= 16'hC005; reload_we <= 1'b1;
        @(negedge clk); reload_we <= 1'b0;
        sof(11'h123);                       // R4 reload, R9 frame load
        check("R5 reload masked", count_rd, 5);
        check("R9 frame loaded", status_rd[10:0], 11'h123);
        // R8: repeated timeouts with ie high, saturation
        tmo_ie <= 1'b1;
        cyc(70);
        check("R8 tally saturates", status_rd[14:12], 7);
        check("R10 irq set", irq, 1);
        // R7: clear held across timeouts, then clear in quiet period
        flag_clr <= 1'b1; cyc(15); flag_clr <= 1'b0;
        eop();                              // R8 clear tally, R4 reload
        check("R8 tally cleared by EOP", status_rd[14:12], 0);
        flag_clr <= 1'b1; @(negedge clk); flag_clr <= 1'b0;
        check("R7 flag cleared", status_rd[15], 0);
        // R9: low-speed SOF does not change frame
        low_speed <= 1'b1;
        sof(11'h7FF);
        check("R9 low-speed frame unchanged", status_rd[10:0], 11'h123);
        low_speed <= 1'b0;
        // R1: irregular tick
        tick_mode = 2;
        cyc(40);
        sof(11'h055);
        cyc(7);
        // R8: ie low freezes tally through timeouts
        tmo_ie <= 1'b0;
        cyc(60);
        tmo_ie <= 1'b1; @(negedge clk);
        check("R10 irq reappears with enable", irq, 1);
        // R4: marker with no tick, and write in same cycle as marker
        tick_mode = 0;
        reload_wdata <= 16'h0009; reload_we <= 1'b1; sof_frame <= 11'h2AA; sof_stb <= 1'b1;
        @(negedge clk); reload_we <= 1'b0; sof_stb <= 1'b0;
        check("R4 old reload used", count_rd, 5);
        tick_mode = 1;
        cyc(30);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule